// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block places received Ethernet frames into memory buffers. Software describes each buffer with a four-word descriptor, and the descriptors sit in a ring at a base address that software chooses. The engine takes bytes from a valid/ready stream. The last beat of each frame carries an end marker and error flags. The engine fetches the current descriptor through a word-wide request/grant memory port. It uses the descriptor only when software has handed it over. It stores the frame bytes one byte lane at a time. It then returns the descriptor to software with one status write, and that write also clears the ownership bit.

A frame larger than one buffer is split across consecutive descriptors. A marker bit in a descriptor sends the engine back to the ring base after that descriptor. If a descriptor is not yet owned when a frame is waiting, the engine signals a missing buffer, holds the stream and reads the descriptor again after a programmable pause. Three single-cycle event outputs report a completed frame, a missing buffer and an upstream overflow.

Top module: `rx_desc_dma`

## Requirements
- R1: During and just after reset, rx_ready_o, mem_req_o and all three event outputs are low. The first descriptor used after reset is at ring_base_i.
- R2: Descriptor i occupies the 16 bytes at ring_base_i + 16*i. Word 0 is at offset 0, word 1 at +4 and word 2 at +8. The engine uses a descriptor only when bit 31 of word 0 is set. If that bit is clear, irq_nobuf_o pulses, rx_ready_o stays low, and word 0 is read again after poll_cnt_i+1 idle cycles.
- R3: Byte k of a segment goes to byte address (word 2) + k. The write has exactly one strobe set, at lane address[1:0], and the byte is replicated on all four lanes of mem_wdata_o.
- R4: Status goes back as one full-word write to word 0. Bit 31 is 0, bit 30 is the first-segment flag, bit 29 is the last-segment flag, and bits [10:0] hold the number of bytes in that segment. Every other bit is 0 unless R6 sets it.
- R5: The buffer size is word 1 bits [10:0]. When a buffer fills before the frame ends, the frame continues in the next descriptor. Only the first segment carries bit 30, and only the final segment carries bit 29.
- R6: Only the final segment carries the frame flags. Bit 26 is the receive error, bit 25 the CRC error and bit 22 the odd nibble, all taken from the end beat. Bit 24 is set when the total length exceeds 1518 bytes. Bit 23 is set when the total length is under 64 bytes. Bit 28 is set when bit 0 of the first byte is 1 (multicast).
- R7: After a descriptor whose word 1 bit 31 is set, the next descriptor is at ring_base_i. Otherwise the next descriptor is 16 bytes further on.
- R8: Word 3 of a descriptor (offset 12) is never read or written.
- R9: irq_done_o pulses for one cycle, in the cycle after the final segment's status write is granted.
- R10: irq_lost_o pulses in the cycle after rx_ovf_i is high.
- R11: While rx_en_i is low, no new frame starts: no memory request is made and rx_ready_o stays low.
- R12: A soft_rst_i pulse aborts any transfer and returns the ring index to 0.
- R13: A memory request stays asserted, with its address and write enable unchanged, until mem_gnt_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Allows a new frame to start |
| soft_rst_i | input | 1 | Single-cycle pulse that returns the ring index to 0 |
| ring_base_i | input | AW | Byte address of descriptor 0 |
| poll_cnt_i | input | PCW | Idle cycles minus one before an unowned descriptor is read again |
| rx_valid_i | input | 1 | Stream beat valid |
| rx_ready_o | output | 1 | Stream beat accepted |
| rx_data_i | input | 8 | Stream byte |
| rx_last_i | input | 1 | Beat is the end of the frame |
| rx_err_i | input | 1 | Receive error flag, read on the end beat |
| rx_crc_err_i | input | 1 | CRC error flag, read on the end beat |
| rx_odd_i | input | 1 | Odd-nibble flag, read on the end beat |
| rx_ovf_i | input | 1 | Upstream overflow pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address |
| mem_be_o | output | 4 | Byte strobes |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |
| irq_done_o | output | 1 | Frame-completed event |
| irq_nobuf_o | output | 1 | Missing-buffer event |
| irq_lost_o | output | 1 | Packet-lost event |

## Verification
Random frame lengths from 20 to 1600 bytes against 512-byte buffers give frames of one to four segments. These show whether the first and last flags and the per-segment counts follow the split, and whether descriptors wrap at the marked entry. Directed lengths of 40, 512, 513 and 1530 bytes probe the runt and too-long limits, an exact buffer fill, and a one-byte trailing segment. Separate cases cover a frame start with the enable off, a descriptor still held by software, an overflow pulse, and a soft reset while the ring index is not 0. These tell apart a stall without a fetch, polling, event timing and an index that returns to 0.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_POLL, ST_RD1, ST_RD2, ST_DATA, ST_WB, ST_STAT
  } rxd_state_e;

  localparam int LEN_W    = 11;
  localparam int OWN_B    = 31;
  localparam int FIRST_B  = 30;
  localparam int LAST_B   = 29;
  localparam int MCAST_B  = 28;
  localparam int RXERR_B  = 26;
  localparam int CRCERR_B = 25;
  localparam int LONG_B   = 24;
  localparam int RUNT_B   = 23;
  localparam int ODD_B    = 22;
  localparam int EOR_B    = 31;
endpackage

// File: rtl/rxd_ring_addr.sv
module rxd_ring_addr #(
  parameter int AW = 32,
  parameter int IW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  input  logic [AW-1:0] base_i,
  input  logic [1:0]    word_i,
  output logic [AW-1:0] addr_o
);
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (adv_i)  idx_q <= wrap_i ? '0 : idx_q + 1'b1;
  end

  assign addr_o = base_i + AW'({idx_q, word_i, 2'b00});
endmodule

// File: rtl/rxd_poll_timer.sv
module rxd_poll_timer #(
  parameter int PCW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           run_i,
  input  logic [PCW-1:0] cnt_i,
  output logic           done_o
);
  logic [PCW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= cnt_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/rxd_status.sv
module rxd_status
  import rxd_pkg::*;
#(
  parameter int TLW     = 12,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic             first_i,
  input  logic             last_i,
  input  logic             mcast_i,
  input  logic             err_i,
  input  logic             crc_i,
  input  logic             odd_i,
  input  logic [TLW-1:0]   tot_i,
  input  logic [LEN_W-1:0] seg_i,
  output logic [31:0]      word_o
);
  always_comb begin
    word_o              = '0;
    word_o[LEN_W-1:0]   = seg_i;
    word_o[FIRST_B]     = first_i;
    if (last_i) begin
      word_o[LAST_B]    = 1'b1;
      word_o[MCAST_B]   = mcast_i;
      word_o[RXERR_B]   = err_i;
      word_o[CRCERR_B]  = crc_i;
      word_o[ODD_B]     = odd_i;
      word_o[LONG_B]    = (32'(tot_i) > 32'(MAX_LEN));
      word_o[RUNT_B]    = (32'(tot_i) < 32'(MIN_LEN));
    end
  end
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
  import rxd_pkg::*;
#(
  parameter int AW      = 32,
  parameter int IW      = 10,
  parameter int PCW     = 8,
  parameter int TLW     = 12,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rx_en_i,
  input  logic           soft_rst_i,
  input  logic [AW-1:0]  ring_base_i,
  input  logic [PCW-1:0] poll_cnt_i,
  input  logic           rx_valid_i,
  output logic           rx_ready_o,
  input  logic [7:0]     rx_data_i,
  input  logic           rx_last_i,
  input  logic           rx_err_i,
  input  logic           rx_crc_err_i,
  input  logic           rx_odd_i,
  input  logic           rx_ovf_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [3:0]     mem_be_o,
  output logic [31:0]    mem_wdata_o,
  input  logic           mem_gnt_i,
  input  logic [31:0]    mem_rdata_i,
  output logic           irq_done_o,
  output logic           irq_nobuf_o,
  output logic           irq_lost_o
);
  rxd_state_e       state_q;
  logic [AW-1:0]    buf_addr_q, desc_addr, wb_addr;
  logic [LEN_W-1:0] buf_size_q, seg_q, seg_n;
  logic [TLW-1:0]   tot_q;
  logic             eor_q, first_q, mcast_q, last_q, err_q, crc_q, odd_q;
  logic [7:0]       byte_q;
  logic [1:0]       word_sel;
  logic [31:0]      status_w;
  logic             poll_done, gnt_rd0, stat_done;
  logic             unused_rdata;

  assign unused_rdata = ^mem_rdata_i[30:LEN_W];

  assign word_sel  = (state_q == ST_RD1) ? 2'd1 : (state_q == ST_RD2) ? 2'd2 : 2'd0;
  assign gnt_rd0   = (state_q == ST_RD0) && mem_gnt_i;
  assign stat_done = (state_q == ST_STAT) && mem_gnt_i;
  assign seg_n     = seg_q + 1'b1;
  assign wb_addr   = buf_addr_q + AW'(seg_q);

  rxd_ring_addr #(.AW(AW), .IW(IW)) u_ring (
    .clk_i, .rst_ni,
    .clr_i  (soft_rst_i),
    .adv_i  (stat_done && !soft_rst_i),
    .wrap_i (eor_q),
    .base_i (ring_base_i),
    .word_i (word_sel),
    .addr_o (desc_addr)
  );

  rxd_poll_timer #(.PCW(PCW)) u_poll (
    .clk_i, .rst_ni,
    .load_i (gnt_rd0 && !mem_rdata_i[OWN_B]),
    .run_i  (state_q == ST_POLL),
    .cnt_i  (poll_cnt_i),
    .done_o (poll_done)
  );

  rxd_status #(.TLW(TLW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_stat (
    .first_i (first_q), .last_i (last_q), .mcast_i (mcast_q),
    .err_i   (err_q),   .crc_i  (crc_q),  .odd_i   (odd_q),
    .tot_i   (tot_q),   .seg_i  (seg_q),  .word_o  (status_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      buf_addr_q <= '0;
      buf_size_q <= '0;
      seg_q      <= '0;
      tot_q      <= '0;
      eor_q      <= 1'b0;
      first_q    <= 1'b1;
      mcast_q    <= 1'b0;
      last_q     <= 1'b0;
      err_q      <= 1'b0;
      crc_q      <= 1'b0;
      odd_q      <= 1'b0;
      byte_q     <= '0;
    end else if (soft_rst_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rx_en_i && rx_valid_i) begin
          state_q <= ST_RD0;
          tot_q   <= '0;
          first_q <= 1'b1;
          mcast_q <= 1'b0;
        end
        ST_RD0: if (mem_gnt_i) state_q <= mem_rdata_i[OWN_B] ? ST_RD1 : ST_POLL;
        ST_POLL: if (poll_done) state_q <= ST_RD0;
        ST_RD1: if (mem_gnt_i) begin
          buf_size_q <= mem_rdata_i[LEN_W-1:0];
          eor_q      <= mem_rdata_i[EOR_B];
          state_q    <= ST_RD2;
        end
        ST_RD2: if (mem_gnt_i) begin
          buf_addr_q <= mem_rdata_i[AW-1:0];
          seg_q      <= '0;
          state_q    <= ST_DATA;
        end
        ST_DATA: if (rx_valid_i) begin
          byte_q  <= rx_data_i;
          last_q  <= rx_last_i;
          err_q   <= rx_err_i;
          crc_q   <= rx_crc_err_i;
          odd_q   <= rx_odd_i;
          if (tot_q == '0) mcast_q <= rx_data_i[0];
          state_q <= ST_WB;
        end
        ST_WB: if (mem_gnt_i) begin
          seg_q <= seg_n;
          if (tot_q != '1) tot_q <= tot_q + 1'b1;
          state_q <= (last_q || seg_n == buf_size_q) ? ST_STAT : ST_DATA;
        end
        ST_STAT: if (mem_gnt_i) begin
          first_q <= 1'b0;
          state_q <= last_q ? ST_IDLE : ST_RD0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_done_o  <= 1'b0;
      irq_nobuf_o <= 1'b0;
      irq_lost_o  <= 1'b0;
    end else begin
      irq_done_o  <= stat_done && last_q && !soft_rst_i;
      irq_nobuf_o <= gnt_rd0 && !mem_rdata_i[OWN_B] && !soft_rst_i;
      irq_lost_o  <= rx_ovf_i;
    end
  end

  assign rx_ready_o  = (state_q == ST_DATA);
  assign mem_req_o   = (state_q inside {ST_RD0, ST_RD1, ST_RD2, ST_WB, ST_STAT});
  assign mem_we_o    = (state_q inside {ST_WB, ST_STAT});
  assign mem_addr_o  = (state_q == ST_WB) ? wb_addr : desc_addr;
  assign mem_be_o    = (state_q == ST_WB) ? (4'b0001 << wb_addr[1:0]) : 4'hf;
  assign mem_wdata_o = (state_q == ST_WB) ? {4{byte_q}} : status_w;
endmodule

// File: rtl/rx_desc_dma_chk.sv
module rx_desc_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          soft_rst_i,
  input logic          rx_ovf_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [3:0]    mem_be_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_gnt_i,
  input logic          irq_done_o,
  input logic          irq_lost_o
);
  AST_WORD3_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && (!mem_we_o || mem_be_o == 4'hf) |-> mem_addr_o[3:2] != 2'b11); // R8

  AST_STATUS_RETURNS_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_be_o == 4'hf |-> !mem_wdata_o[31]); // R4

  AST_BYTE_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_be_o != 4'hf
      |-> $countones(mem_be_o) == 1 && mem_be_o[mem_addr_o[1:0]]); // R3

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i && !soft_rst_i
      |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R13

  AST_DONE_AFTER_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |-> $past(mem_req_o && mem_we_o && mem_gnt_i && mem_be_o == 4'hf)); // R9

  AST_LOST_FOLLOWS_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovf_i |=> irq_lost_o); // R10
endmodule

bind rx_desc_dma rx_desc_dma_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .soft_rst_i, .rx_ovf_i, .mem_req_o, .mem_we_o,
  .mem_addr_o, .mem_be_o, .mem_wdata_o, .mem_gnt_i, .irq_done_o, .irq_lost_o
);

// File: tb/rx_desc_dma_tb.sv
module rx_desc_dma_tb;
  localparam int RING = 'h100;
  localparam int BUFB = 'h400;
  localparam int BSZ  = 512;
  localparam int ND   = 8;
  localparam logic [31:0] OWN = 32'h8000_0000;

  logic clk = 0, rst_ni = 0;
  logic rx_en_i = 0, soft_rst_i = 0;
  logic [31:0] ring_base_i = RING;
  logic [7:0]  poll_cnt_i = 8'd3;
  logic rx_valid_i = 0, rx_last_i = 0, rx_err_i = 0, rx_crc_err_i = 0, rx_odd_i = 0, rx_ovf_i = 0;
  logic [7:0] rx_data_i = 0;
  logic rx_ready_o, mem_req_o, mem_we_o, mem_gnt_i = 0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [3:0]  mem_be_o;
  logic irq_done_o, irq_nobuf_o, irq_lost_o;

  logic [31:0] mem [0:2047];
  logic [7:0]  fb [0:2047];
  int checks = 0, fails = 0, sw_ptr = 0;
  int done_cnt = 0, nobuf_cnt = 0;

  always #4 clk = ~clk;

  rx_desc_dma u_dut (
    .clk_i(clk), .rst_ni, .rx_en_i, .soft_rst_i, .ring_base_i, .poll_cnt_i,
    .rx_valid_i, .rx_ready_o, .rx_data_i, .rx_last_i, .rx_err_i, .rx_crc_err_i,
    .rx_odd_i, .rx_ovf_i, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o,
    .mem_wdata_o, .mem_gnt_i, .mem_rdata_i, .irq_done_o, .irq_nobuf_o, .irq_lost_o
  );

  assign mem_rdata_i = mem[mem_addr_o[12:2]];

  always @(posedge clk) begin
    if (mem_req_o && mem_we_o && mem_gnt_i)
      for (int b = 0; b < 4; b++)
        if (mem_be_o[b]) mem[mem_addr_o[12:2]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
    if (irq_done_o)  done_cnt++;
    if (irq_nobuf_o) nobuf_cnt++;
  end

  always @(negedge clk) mem_gnt_i = ($urandom_range(3) != 0);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_w0(int n, bit first, bit last, bit mc,
                                         bit e, bit c, bit o, int len);
    logic [31:0] w = 32'(n);
    w[30] = first;
    if (last) begin
      w[29] = 1; w[28] = mc; w[26] = e; w[25] = c; w[22] = o;
      w[24] = (len > 1518); w[23] = (len < 64);
    end
    return w;
  endfunction

  task automatic send_frame(int len, bit mc, bit e, bit c, bit o);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    fb[0][0] = mc;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid_i = 1; rx_data_i = fb[i]; rx_last_i = (i == len - 1);
      rx_err_i = rx_last_i & e; rx_crc_err_i = rx_last_i & c; rx_odd_i = rx_last_i & o;
      while (!rx_ready_o) @(negedge clk);
    end
    @(negedge clk);
    rx_valid_i = 0; rx_last_i = 0; rx_err_i = 0; rx_crc_err_i = 0; rx_odd_i = 0;
  endtask

  task automatic wait_done(int start);
    while (done_cnt == start) @(negedge clk);
  endtask

  task automatic check_frame(int len, bit e, bit c, bit o);
    int off = 0, seg = 0;
    while (off < len) begin
      int n = (len - off > BSZ) ? BSZ : len - off;
      bit last = (off + n == len);
      int d = sw_ptr, wi = (RING >> 2) + d * 4, bad = 0;
      logic [31:0] ex = exp_w0(n, seg == 0, last, fb[0][0], e, c, o, len);
      chk(mem[wi] == ex, "R4 R5 R6 R7 status word", mem[wi], ex);
      for (int k = 0; k < n; k++) begin
        int a = BUFB + d * BSZ + k;
        if (mem[a >> 2][8 * (a % 4) +: 8] != fb[off + k]) bad++;
      end
      chk(bad == 0, "R3 buffer bytes", bad, 0);
      chk(mem[wi + 3] == (32'hC0DE_0000 | d), "R8 word3", mem[wi + 3], 32'hC0DE_0000 | d);
      mem[wi] = OWN;
      sw_ptr = (sw_ptr + 1) % ND;
      off += n; seg++;
    end
  endtask

  task automatic frame(int len, bit mc, bit e, bit c, bit o);
    int s = done_cnt;
    send_frame(len, mc, e, c, o);
    wait_done(s);
    repeat (3) @(negedge clk);
    chk(done_cnt == s + 1, "R9 one done pulse", done_cnt, s + 1);
    check_frame(len, e, c, o);
  endtask

  initial begin
    int reqs, rdys, s, n0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    for (int d = 0; d < ND; d++) begin
      mem[(RING >> 2) + d * 4]     = OWN;
      mem[(RING >> 2) + d * 4 + 1] = ((d == ND - 1) ? 32'h8000_0000 : 0) | BSZ;
      mem[(RING >> 2) + d * 4 + 2] = BUFB + d * BSZ;
      mem[(RING >> 2) + d * 4 + 3] = 32'hC0DE_0000 | d;
    end
    repeat (5) @(negedge clk);
    chk({rx_ready_o, mem_req_o, irq_done_o, irq_nobuf_o, irq_lost_o} == 0, "R1 in reset",
        {rx_ready_o, mem_req_o, irq_done_o, irq_nobuf_o, irq_lost_o}, 0);
    rst_ni = 1;
    @(negedge clk);
    chk({rx_ready_o, mem_req_o, irq_done_o, irq_nobuf_o, irq_lost_o} == 0, "R1 after reset",
        {rx_ready_o, mem_req_o, irq_done_o, irq_nobuf_o, irq_lost_o}, 0);

    // R11: stream valid but engine disabled
    rx_valid_i = 1; rx_data_i = 8'h55; reqs = 0; rdys = 0;
    repeat (30) begin @(negedge clk); reqs += mem_req_o; rdys += rx_ready_o; end
    chk(reqs == 0 && rdys == 0, "R11 disabled stays quiet", reqs + rdys, 0);
    rx_valid_i = 0;
    @(negedge clk);
    rx_en_i = 1;

    frame(100, 1, 0, 0, 0);    // R1 first frame at base, multicast
    frame(512, 0, 0, 0, 0);    // exact buffer fill
    frame(513, 0, 0, 0, 0);    // one-byte tail segment
    frame(40, 0, 1, 0, 0);     // runt with error
    frame(1530, 1, 0, 1, 1);   // too long, crc, odd
    frame(64, 0, 0, 0, 0);     // runt boundary
    frame(1518, 0, 0, 0, 0);   // too-long boundary
    for (int i = 0; i < 14; i++)
      frame($urandom_range(20, 1600), $urandom_range(1), $urandom_range(7) == 0,
            $urandom_range(7) == 0, $urandom_range(7) == 0);

    // R2: descriptor held by software
    mem[(RING >> 2) + sw_ptr * 4] = '0;
    n0 = nobuf_cnt; s = done_cnt;
    fork
      send_frame(200, 0, 0, 0, 0);
      begin
        while (nobuf_cnt == n0) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(rx_ready_o == 0 && done_cnt == s, "R2 stalled without buffer", rx_ready_o, 0);
        mem[(RING >> 2) + sw_ptr * 4] = OWN;
      end
    join
    wait_done(s);
    repeat (3) @(negedge clk);
    chk(nobuf_cnt - n0 >= 2, "R2 polling repeated nobuf", nobuf_cnt - n0, 2);
    check_frame(200, 0, 0, 0);

    // R10
    @(negedge clk); rx_ovf_i = 1;
    @(negedge clk); rx_ovf_i = 0;
    chk(irq_lost_o == 1, "R10 lost pulse", irq_lost_o, 1);
    @(negedge clk);
    chk(irq_lost_o == 0, "R10 lost one cycle", irq_lost_o, 0);

    // R12
    if (sw_ptr == 0) frame(80, 0, 0, 0, 0);
    @(negedge clk); soft_rst_i = 1;
    @(negedge clk); soft_rst_i = 0;
    sw_ptr = 0;
    s = done_cnt;
    send_frame(90, 0, 0, 0, 0);
    wait_done(s);
    repeat (3) @(negedge clk);
    chk(mem[RING >> 2] == exp_w0(90, 1, 1, 0, 0, 0, 0, 90), "R12 index back to 0",
        mem[RING >> 2], exp_w0(90, 1, 1, 0, 0, 0, 0, 90));
    check_frame(90, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule